// File: doc/BRIEF.md
# Double-Buffered Plane Control with Self-Refresh Gating

This block models the display-side timing of a plane control register that software writes through a shadow copy. At each vertical-blank strobe the shadow value moves into the live register that drives the plane. The move is refused while memory self-refresh is active, and any refused update stays queued in the shadow.

Self-refresh is controlled by a software enable bit. That bit is never applied when it is written. It is only looked at on the frame-start strobe. At that moment self-refresh turns on if the enable bit is set and the processor reports its active (C0) state; otherwise it turns off. In every frame, frame start follows vblank start. Software that clears the enable bit shortly before a vblank therefore still sees that vblank's update refused. To shut a plane down reliably, software must turn self-refresh off first, then write the plane, then wait one further vblank.

Top module: `plnsr_top`

## Requirements
- R1: After reset the live control word is all zeros, the plane is off, self-refresh is inactive, no update is pending and both status pulses are low.
- R2: A shadow write sets the pending flag and leaves the live control word unchanged until a vblank strobe.
- R3: A vblank strobe with an update pending and self-refresh inactive copies the shadow word into the live word on the next clock. It also clears the pending flag and raises the done pulse for exactly one cycle.
- R4: A vblank strobe with an update pending and self-refresh active leaves the live word unchanged and keeps the update pending. It also raises the blocked pulse for exactly one cycle.
- R5: Changing the self-refresh enable bit or the C0 input has no effect on the self-refresh state except at a frame-start strobe. A vblank in the same cycle as a frame start is judged on the self-refresh state from before that frame start.
- R6: At a frame-start strobe, self-refresh becomes active exactly when the enable bit is 1 and the C0 input is 1. In every other combination it becomes inactive.
- R7: When a shadow write and a vblank strobe arrive in the same cycle, the newly written word is the one that is copied or queued.
- R8: A refused update is retried at every later vblank and is committed at the first one that finds self-refresh inactive.
- R9: A vblank strobe with no update pending changes nothing and raises neither pulse.
- R10: The plane-on output always equals bit 0 of the live control word, which is the plane-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Shadow write strobe |
| sw_data | input | CTRL_W | Word written to the shadow |
| vbl_start | input | 1 | Vertical blank start strobe |
| frm_start | input | 1 | Frame start strobe |
| sr_en_bit | input | 1 | Software self-refresh enable |
| cpu_c0 | input | 1 | Processor is in its active state |
| live_ctrl | output | CTRL_W | Live plane control word |
| plane_on | output | 1 | Live plane-enable bit |
| sr_live | output | 1 | Self-refresh currently active |
| upd_pending | output | 1 | Shadow holds an uncommitted update |
| upd_blocked | output | 1 | One-cycle pulse: vblank copy refused |
| upd_done | output | 1 | One-cycle pulse: vblank copy committed |

## Verification
The hardest state to reach is a vblank that finds an update pending while self-refresh is already latched on. Reaching it takes a frame start with both enable and C0 set, then a write, then a vblank. Clearing the enable bit before the next vblank must not help, because a frame start has to come between them. The stimulus walks through exactly this sequence. It also puts a write, or a frame start, in the same cycle as a vblank, which checks the ordering of events that arrive together.

// File: rtl/plnsr_pkg.sv
package plnsr_pkg;
  localparam int PLANE_EN_BIT = 0;

  // self-refresh decision taken at frame start
  function automatic logic sr_decide(input logic en, input logic c0);
    return en & c0;
  endfunction

  // word that a vblank copy would use this cycle
  function automatic logic [63:0] pick_word(input logic wr, input logic [63:0] wdata,
                                            input logic [63:0] held);
    return wr ? wdata : held;
  endfunction
endpackage

// File: rtl/plnsr_srctl.sv
module plnsr_srctl
  import plnsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic sr_en_bit,
  input  logic cpu_c0,
  output logic sr_live
);
  logic sr_q;
  logic sr_eval;   // frame-start evaluation event
  logic sr_next;

  assign sr_eval = frm_start;
  assign sr_next = sr_decide(sr_en_bit, cpu_c0);

  always_ff @(posedge clk) begin
    if (!rst_n)       sr_q <= 1'b0;
    else if (sr_eval) sr_q <= sr_next;
  end

  assign sr_live = sr_q;

  // R5: state only moves at frame start
  a_r5_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> $stable(sr_live));
  // R6: frame start applies enable AND C0
  a_r6_sr_eval: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (sr_live == $past(sr_en_bit && cpu_c0)));
endmodule

// File: rtl/plnsr_dbuf.sv
module plnsr_dbuf
  import plnsr_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [CTRL_W-1:0] sw_data,
  input  logic              vbl_start,
  input  logic              sr_live,
  output logic [CTRL_W-1:0] live_ctrl,
  output logic              upd_pending,
  output logic              upd_blocked,
  output logic              upd_done
);
  logic [CTRL_W-1:0] shadow_q, live_q, cand_word;
  logic              pend_q, blk_q, done_q;
  logic              copy_req, copy_go, copy_refused;
  logic [63:0]       cand_wide;

  assign copy_req     = vbl_start && (pend_q || sw_wr);
  assign copy_go      = copy_req && !sr_live;
  assign copy_refused = copy_req && sr_live;
  assign cand_wide    = pick_word(sw_wr, 64'(sw_data), 64'(shadow_q));
  assign cand_word    = cand_wide[CTRL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      live_q   <= '0;
      pend_q   <= 1'b0;
      blk_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (sw_wr) shadow_q <= sw_data;
      if (copy_go) live_q <= cand_word;
      if (copy_go)    pend_q <= 1'b0;
      else if (sw_wr) pend_q <= 1'b1;
      blk_q  <= copy_refused;
      done_q <= copy_go;
    end
  end

  assign live_ctrl   = live_q;
  assign upd_pending = pend_q;
  assign upd_blocked = blk_q;
  assign upd_done    = done_q;

  // R2: live word only moves at vblank
  a_r2_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vbl_start |=> $stable(live_ctrl));
  // R4: refused copy keeps live word and pending
  a_r4_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && sr_live) |=> ($stable(live_ctrl) && upd_pending == $past(pend_q || sw_wr)));
  // R3: committed copy clears pending
  a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && !sr_live && (upd_pending || sw_wr)) |=> (!upd_pending && upd_done));
  // R9: idle vblank raises nothing
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && !upd_pending && !sw_wr) |=> (!upd_done && !upd_blocked));
  // R4/R3: pulses exclusive
  a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_done, upd_blocked}));
endmodule

// File: rtl/plnsr_top.sv
module plnsr_top
  import plnsr_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [CTRL_W-1:0] sw_data,
  input  logic              vbl_start,
  input  logic              frm_start,
  input  logic              sr_en_bit,
  input  logic              cpu_c0,
  output logic [CTRL_W-1:0] live_ctrl,
  output logic              plane_on,
  output logic              sr_live,
  output logic              upd_pending,
  output logic              upd_blocked,
  output logic              upd_done
);
  logic sr_state;

  plnsr_srctl u_sr (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
    .sr_en_bit(sr_en_bit), .cpu_c0(cpu_c0), .sr_live(sr_state)
  );

  plnsr_dbuf #(.CTRL_W(CTRL_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_data(sw_data),
    .vbl_start(vbl_start), .sr_live(sr_state), .live_ctrl(live_ctrl),
    .upd_pending(upd_pending), .upd_blocked(upd_blocked), .upd_done(upd_done)
  );

  assign sr_live  = sr_state;
  assign plane_on = live_ctrl[PLANE_EN_BIT];

  // R10: plane-on tracks the enable bit of the live word
  a_r10_plane: assert property (@(posedge clk) disable iff (!rst_n)
    plane_on == live_ctrl[PLANE_EN_BIT]);
endmodule

// File: tb/plnsr_tb.sv
module plnsr_top_tb_top;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic sw_wr = 0, vbl_start = 0, frm_start = 0, sr_en_bit = 0, cpu_c0 = 0;
  logic [W-1:0] sw_data = '0;
  logic [W-1:0] live_ctrl;
  logic plane_on, sr_live, upd_pending, upd_blocked, upd_done;

  always #4 clk = ~clk;

  plnsr_top #(.CTRL_W(W)) dut_i (.*);

  typedef struct {
    logic [W-1:0] live; logic pl; logic sr; logic pend; logic blk; logic done;
    string tag;
  } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;

  // independent reference state
  logic [W-1:0] m_live = '0, m_sh = '0;
  logic m_pend = 0, m_sr = 0;

  task automatic step(input logic wr, input logic [W-1:0] d, input logic vb,
                      input logic fs, input logic en, input logic c0, input string tag);
    exp_t e;
    logic [W-1:0] nsh;
    logic req;
    @(negedge clk);
    sw_wr = wr; sw_data = d; vbl_start = vb; frm_start = fs; sr_en_bit = en; cpu_c0 = c0;
    req = vb && (m_pend || wr);
    nsh = wr ? d : m_sh;
    e.blk  = req && m_sr;
    e.done = req && !m_sr;
    if (e.done) m_live = nsh;
    m_pend = e.done ? 1'b0 : (m_pend || wr);
    m_sh = nsh;
    if (fs) m_sr = en && c0;
    e.live = m_live; e.pl = m_live[0]; e.sr = m_sr; e.pend = m_pend; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic en, input logic c0, input string tag);
    step(0, '0, 0, 0, en, c0, tag);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (live_ctrl !== e.live || plane_on !== e.pl || sr_live !== e.sr ||
            upd_pending !== e.pend || upd_blocked !== e.blk || upd_done !== e.done) begin
          n_fail++;
          $display("FAIL %s: act live=%h pl=%b sr=%b pend=%b blk=%b done=%b exp live=%h pl=%b sr=%b pend=%b blk=%b done=%b",
                   e.tag, live_ctrl, plane_on, sr_live, upd_pending, upd_blocked, upd_done,
                   e.live, e.pl, e.sr, e.pend, e.blk, e.done);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    n_run++;
    if (live_ctrl !== '0 || plane_on !== 0 || sr_live !== 0 || upd_pending !== 0 ||
        upd_blocked !== 0 || upd_done !== 0) begin
      n_fail++;
      $display("FAIL R1: act live=%h sr=%b pend=%b exp all zero", live_ctrl, sr_live, upd_pending);
    end
    idle(0, 0, "R1");
    // R2: write without vblank
    step(1, 8'hA5, 0, 0, 0, 0, "R2");
    idle(0, 0, "R2");
    // R3/R10: commit, plane on
    step(0, '0, 1, 0, 0, 0, "R3");
    idle(0, 0, "R10");
    // R9: idle vblank
    step(0, '0, 1, 0, 0, 0, "R9");
    // R5: enable without frame start
    idle(1, 1, "R5");
    step(0, '0, 0, 0, 1, 1, "R5");
    // R6: frame start with en&c0
    step(0, '0, 0, 1, 1, 1, "R6");
    // R4: write plane off, vblank refused
    step(1, 8'h40, 0, 0, 1, 1, "R2");
    step(0, '0, 1, 0, 1, 1, "R4");
    idle(1, 1, "R4");
    // R5: clear enable, same frame vblank still refused
    idle(0, 1, "R5");
    step(0, '0, 1, 0, 0, 1, "R5");
    // R5: vblank together with frame start uses old state
    step(0, '0, 1, 1, 0, 1, "R5");
    // R8: retry commits
    step(0, '0, 1, 0, 0, 1, "R8");
    idle(0, 1, "R10");
    // R6 combos
    step(0, '0, 0, 1, 1, 0, "R6");
    step(0, '0, 0, 1, 0, 1, "R6");
    step(0, '0, 0, 1, 0, 0, "R6");
    step(0, '0, 0, 1, 1, 1, "R6");
    step(0, '0, 0, 1, 0, 0, "R6");
    // R7: write and vblank together, self-refresh off
    step(1, 8'h3B, 1, 0, 0, 0, "R7");
    idle(0, 0, "R7");
    // R7: together with self-refresh on: new word queued
    step(0, '0, 0, 1, 1, 1, "R6");
    step(1, 8'h11, 0, 0, 1, 1, "R2");
    step(1, 8'hC6, 1, 0, 1, 1, "R7");
    step(0, '0, 1, 0, 1, 1, "R8");
    step(0, '0, 0, 1, 0, 0, "R6");
    step(0, '0, 1, 0, 0, 0, "R7");
    idle(0, 0, "R10");
    step(0, '0, 1, 0, 0, 0, "R9");
    idle(0, 0, "R9");
    wait (q.size() == 0);
    @(posedge clk); #3;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule